// File: doc/BRIEF.md
# Predication mask lookup unit

This unit turns a small key-value table of predication rules into a per-register view. Each rule is keyed by an operand register number together with a register-file type: integer or floating-point. The rule names an integer register whose bits serve as the element mask. When an instruction operand is presented for lookup, the unit resolves the rule and drives the address of the predicate register to an external integer register file. It then returns the mask, with optional inversion, a zeroing flag, and the element-enable vector split into elements to compute and elements to clear.

The table holds sixteen 14-bit rules and is written through a simple write port. The rules are expanded into two direct-indexed maps of 32 slots each, one for the integer file and one for the floating-point file, so that a lookup only needs one indexed read. The external register file is expected to return read data in the same cycle as the address. All lookup results are registered and appear one cycle after the request, together with a valid strobe.

Top module: `pred_lookup`

## Requirements
- R1: When tbl_we_i is high at a clock edge, rule tbl_waddr_i takes the value of tbl_wdata_i. Lookups from the next cycle on use the new rule, while a lookup in the same cycle as the write uses the previous mapping. Rule layout: bit 13 bank, bit 12 zero, bit 11 invert, bit 10 type (1 = floating-point), bits 9..5 key register, bits 4..0 predicate register.
- R2: A lookup with lk_fp_i = 1 matches only rules whose type bit is 1, and a lookup with lk_fp_i = 0 matches only rules whose type bit is 0. In both cases the rule's key register must also equal lk_reg_i.
- R3: A lookup that matches no rule returns mask_o all ones, zero_o = 0, act_o equal to the requested element enables and clr_o = 0.
- R4: For a matching lookup, rf_raddr_o in the request cycle is {bank, predicate register}, a 6-bit address with bank as MSB. The value on rf_rdata_i is returned as mask_o.
- R5: When the matching rule has invert set, mask_o is the bitwise complement of the register value read.
- R6: When several rules share the same key and type, the rule with the highest table index decides the result.
- R7: valid_o is high exactly in the cycle after a cycle with lk_req_i high, and low otherwise.
- R8: act_o equals the requested element enables ANDed with mask_o.
- R9: zero_o is set only for a matching rule with zero set. In that case clr_o is the element enables ANDed with the inverted mask. Otherwise clr_o is all zeros, and masked-off elements are left unchanged.
- R10: After reset every rule is zero, so integer register 0 is predicated by integer register 0 without inversion or zeroing, and every other register is unmapped. valid_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tbl_we_i | input | 1 | Rule write enable |
| tbl_waddr_i | input | 4 | Rule index to write |
| tbl_wdata_i | input | 14 | Rule value |
| lk_req_i | input | 1 | Lookup request |
| lk_fp_i | input | 1 | Operand is in the floating-point file |
| lk_reg_i | input | 5 | Operand register number |
| elem_en_i | input | XLEN | Element enables for the operation |
| rf_raddr_o | output | 6 | Predicate register read address |
| rf_rdata_i | input | XLEN | Predicate register value, same cycle |
| valid_o | output | 1 | Result strobe |
| mask_o | output | XLEN | Resolved element mask |
| zero_o | output | 1 | Zeroing applies to masked-off elements |
| act_o | output | XLEN | Elements to compute |
| clr_o | output | XLEN | Elements to write with zero |

## Verification
A rule write and a lookup can coincide in the same cycle, and the lookup must then see the mapping from before the write. The bench presents a write and a lookup of the same key in one cycle, with rules that map the key to different registers. It expects the old redirection, then repeats the lookup alone and expects the new one. Random traffic also mixes writes and lookups freely in the same cycle, and a table model in the bench is updated only after each edge has been checked.

// File: rtl/pred_lookup_pkg.sv
package pred_lookup_pkg;
  localparam int REG_IDX_W = 5;
  localparam int NUM_REG   = 1 << REG_IDX_W;
  localparam int RF_AW     = REG_IDX_W + 1;

  // field order is the software-visible rule layout
  typedef struct packed {
    logic                 bank;
    logic                 zero;
    logic                 inv;
    logic                 is_fp;
    logic [REG_IDX_W-1:0] key_reg;
    logic [REG_IDX_W-1:0] pred_reg;
  } rule_t;

  localparam int RULE_W = $bits(rule_t);

  typedef struct packed {
    logic                 en;
    logic                 zero;
    logic                 inv;
    logic                 bank;
    logic [REG_IDX_W-1:0] pred_reg;
  } slot_t;
endpackage

// File: rtl/pred_rule_tbl.sv
module pred_rule_tbl
  import pred_lookup_pkg::*;
#(
  parameter int NUM_RULE = 16,
  localparam int AW = $clog2(NUM_RULE)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [AW-1:0]          waddr_i,
  input  rule_t                  wdata_i,
  output rule_t [NUM_RULE-1:0]   rules_o
);
  for (genvar e = 0; e < NUM_RULE; e++) begin : g_rule
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rules_o[e] <= '0;
      else if (we_i && waddr_i == AW'(e)) rules_o[e] <= wdata_i;
    end
  end
endmodule

// File: rtl/pred_slot_map.sv
module pred_slot_map
  import pred_lookup_pkg::*;
#(
  parameter int NUM_RULE = 16
) (
  input  rule_t [NUM_RULE-1:0]           rules_i,
  output slot_t [1:0][NUM_REG-1:0]       map_o
);
  // f = 0 integer file, f = 1 floating-point file
  for (genvar f = 0; f < 2; f++) begin : g_file
    for (genvar r = 0; r < NUM_REG; r++) begin : g_slot
      always_comb begin
        map_o[f][r] = '0;
        // later rules overwrite earlier ones
        for (int e = 0; e < NUM_RULE; e++) begin
          if (rules_i[e].is_fp == 1'(f) &&
              rules_i[e].key_reg == REG_IDX_W'(r)) begin
            map_o[f][r].en       = 1'b1;
            map_o[f][r].zero     = rules_i[e].zero;
            map_o[f][r].inv      = rules_i[e].inv;
            map_o[f][r].bank     = rules_i[e].bank;
            map_o[f][r].pred_reg = rules_i[e].pred_reg;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pred_fetch.sv
module pred_fetch
  import pred_lookup_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  slot_t [1:0][NUM_REG-1:0] map_i,
  input  logic                     req_i,
  input  logic                     fp_i,
  input  logic [REG_IDX_W-1:0]     reg_i,
  input  logic [XLEN-1:0]          elem_en_i,
  output logic [RF_AW-1:0]         rf_raddr_o,
  input  logic [XLEN-1:0]          rf_rdata_i,
  output logic                     valid_o,
  output logic [XLEN-1:0]          mask_o,
  output logic                     zero_o,
  output logic [XLEN-1:0]          act_o,
  output logic [XLEN-1:0]          clr_o
);
  slot_t           sel;
  logic [XLEN-1:0] mask_d;
  logic            zero_d;

  assign sel        = map_i[fp_i][reg_i];
  assign rf_raddr_o = sel.en ? {sel.bank, sel.pred_reg} : '0;

  always_comb begin
    if (!sel.en)     mask_d = '1;
    else if (sel.inv) mask_d = ~rf_rdata_i;
    else             mask_d = rf_rdata_i;
    zero_d = sel.en & sel.zero;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mask_o  <= '0;
      zero_o  <= 1'b0;
      act_o   <= '0;
      clr_o   <= '0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        mask_o <= mask_d;
        zero_o <= zero_d;
        act_o  <= elem_en_i & mask_d;
        clr_o  <= zero_d ? (elem_en_i & ~mask_d) : '0;
      end
    end
  end
endmodule

// File: rtl/pred_lookup.sv
module pred_lookup
  import pred_lookup_pkg::*;
#(
  parameter int NUM_RULE = 16,
  parameter int XLEN     = 64,
  localparam int AW      = $clog2(NUM_RULE)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tbl_we_i,
  input  logic [AW-1:0]        tbl_waddr_i,
  input  logic [RULE_W-1:0]    tbl_wdata_i,
  input  logic                 lk_req_i,
  input  logic                 lk_fp_i,
  input  logic [REG_IDX_W-1:0] lk_reg_i,
  input  logic [XLEN-1:0]      elem_en_i,
  output logic [RF_AW-1:0]     rf_raddr_o,
  input  logic [XLEN-1:0]      rf_rdata_i,
  output logic                 valid_o,
  output logic [XLEN-1:0]      mask_o,
  output logic                 zero_o,
  output logic [XLEN-1:0]      act_o,
  output logic [XLEN-1:0]      clr_o
);
  rule_t [NUM_RULE-1:0]     rules;
  slot_t [1:0][NUM_REG-1:0] map;

  pred_rule_tbl #(.NUM_RULE(NUM_RULE)) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_waddr_i),
    .wdata_i (rule_t'(tbl_wdata_i)),
    .rules_o (rules)
  );

  pred_slot_map #(.NUM_RULE(NUM_RULE)) u_map (
    .rules_i (rules),
    .map_o   (map)
  );

  pred_fetch #(.XLEN(XLEN)) u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .map_i      (map),
    .req_i      (lk_req_i),
    .fp_i       (lk_fp_i),
    .reg_i      (lk_reg_i),
    .elem_en_i  (elem_en_i),
    .rf_raddr_o (rf_raddr_o),
    .rf_rdata_i (rf_rdata_i),
    .valid_o    (valid_o),
    .mask_o     (mask_o),
    .zero_o     (zero_o),
    .act_o      (act_o),
    .clr_o      (clr_o)
  );
endmodule

// File: rtl/pred_lookup_chk.sv
module pred_lookup_chk #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            lk_req_i,
  input logic [XLEN-1:0] elem_en_i,
  input logic            valid_o,
  input logic [XLEN-1:0] mask_o,
  input logic            zero_o,
  input logic [XLEN-1:0] act_o,
  input logic [XLEN-1:0] clr_o
);
  // R7
  valid_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> valid_o);
  // R7
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_req_i |=> !valid_o);
  // R8
  act_within_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (act_o & ~mask_o) == '0);
  // R8
  act_within_enables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> (act_o & ~$past(elem_en_i)) == '0);
  // R9
  no_clear_without_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !zero_o) |-> clr_o == '0);
  // R9
  clear_only_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (clr_o & mask_o) == '0);
endmodule

bind pred_lookup pred_lookup_chk #(.XLEN(XLEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .lk_req_i  (lk_req_i),
  .elem_en_i (elem_en_i),
  .valid_o   (valid_o),
  .mask_o    (mask_o),
  .zero_o    (zero_o),
  .act_o     (act_o),
  .clr_o     (clr_o)
);

// File: tb/pred_lookup_bench.sv
`timescale 1ns/1ps
module pred_lookup_bench;
  localparam int XLEN = 64;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            tbl_we_i = 1'b0;
  logic [3:0]      tbl_waddr_i = '0;
  logic [13:0]     tbl_wdata_i = '0;
  logic            lk_req_i = 1'b0;
  logic            lk_fp_i = 1'b0;
  logic [4:0]      lk_reg_i = '0;
  logic [XLEN-1:0] elem_en_i = '0;
  logic [5:0]      rf_raddr_o;
  logic [XLEN-1:0] rf_rdata_i;
  logic            valid_o;
  logic [XLEN-1:0] mask_o;
  logic            zero_o;
  logic [XLEN-1:0] act_o;
  logic [XLEN-1:0] clr_o;

  logic [13:0]     tbl_m [16];
  logic [XLEN-1:0] rf_m  [64];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  // external register file: combinational read
  always_comb rf_rdata_i = rf_m[rf_raddr_o];

  pred_lookup u_pred_lookup (.*);

  // returns {en, zero, inv, bank, pred_reg[4:0]}
  function automatic logic [8:0] exp_slot(logic fp, logic [4:0] r);
    logic [8:0] s = '0;
    for (int e = 0; e < 16; e++)
      if (tbl_m[e][10] == fp && tbl_m[e][9:5] == r)
        s = {1'b1, tbl_m[e][12], tbl_m[e][11], tbl_m[e][13], tbl_m[e][4:0]};
    return s;
  endfunction

  function automatic logic [XLEN-1:0] exp_mask(logic [8:0] s);
    logic [XLEN-1:0] v;
    if (!s[8]) return '1;
    v = rf_m[{s[5], s[4:0]}];
    return s[6] ? ~v : v;
  endfunction

  task automatic chk(bit ok, string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one cycle: optional write and optional lookup, both seen at the same edge
  task automatic cycle(bit we, logic [3:0] wa, logic [13:0] wd,
                       bit rq, logic fp, logic [4:0] r, logic [XLEN-1:0] el,
                       string tag);
    logic [8:0]      s;
    logic [XLEN-1:0] m;
    @(negedge clk_i);
    tbl_we_i = we; tbl_waddr_i = wa; tbl_wdata_i = wd;
    lk_req_i = rq; lk_fp_i = fp; lk_reg_i = r; elem_en_i = el;
    s = exp_slot(fp, r);
    m = exp_mask(s);
    #1;
    if (rq && s[8])
      chk(rf_raddr_o == {s[5], s[4:0]}, {tag, " R4 raddr"},
          XLEN'(rf_raddr_o), XLEN'({s[5], s[4:0]}));
    @(posedge clk_i);
    #1;
    if (rq) begin
      chk(valid_o == 1'b1, {tag, " R7 valid"}, XLEN'(valid_o), 1);
      chk(mask_o == m, {tag, " R2 R3 R5 mask"}, mask_o, m);
      chk(zero_o == (s[8] & s[7]), {tag, " R9 zero"}, XLEN'(zero_o), XLEN'(s[8] & s[7]));
      chk(act_o == (el & m), {tag, " R8 act"}, act_o, el & m);
      chk(clr_o == ((s[8] & s[7]) ? (el & ~m) : '0), {tag, " R9 clr"},
          clr_o, (s[8] & s[7]) ? (el & ~m) : '0);
    end else begin
      chk(valid_o == 1'b0, {tag, " R7 idle"}, XLEN'(valid_o), 0);
    end
    if (we) tbl_m[wa] = wd;
    tbl_we_i = 1'b0; lk_req_i = 1'b0;
  endtask

  function automatic logic [13:0] rule(bit bank, bit z, bit inv, bit fp,
                                       logic [4:0] key, logic [4:0] pr);
    return {bank, z, inv, fp, key, pr};
  endfunction

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [XLEN-1:0] el;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) tbl_m[i] = '0;
    for (int i = 0; i < 64; i++) rf_m[i] = {$urandom, $urandom};
    repeat (3) @(posedge clk_i);
    #1;
    chk(valid_o == 1'b0, "R10 reset valid", XLEN'(valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R10: rule table zero after reset
    rf_m[0] = 64'h0F0F_1234_5678_9ABC;
    cycle(0, 0, 0, 1, 0, 5'd0, '1, "R10 int0");
    cycle(0, 0, 0, 1, 0, 5'd5, '1, "R10 unmapped R3");
    cycle(0, 0, 0, 1, 1, 5'd0, 64'h00FF, "R10 fp0 R3");

    // R4 plain redirection, then R2 type separation
    cycle(1, 4'd3, rule(0, 0, 0, 0, 5'd7, 5'd9), 0, 0, 0, 0, "R1 wr");
    cycle(0, 0, 0, 1, 0, 5'd7, 64'hFFFF_0000_FFFF_0000, "R4 int7");
    cycle(0, 0, 0, 1, 1, 5'd7, 64'hFFFF, "R2 fp7");
    // R5 invert
    cycle(1, 4'd4, rule(0, 0, 1, 1, 5'd7, 5'd11), 0, 0, 0, 0, "R1 wr");
    cycle(0, 0, 0, 1, 1, 5'd7, '1, "R5 fp7 inv");
    // R9 zeroing
    cycle(1, 4'd5, rule(0, 1, 0, 0, 5'd20, 5'd2), 0, 0, 0, 0, "R1 wr");
    cycle(0, 0, 0, 1, 0, 5'd20, 64'h0123_4567_89AB_CDEF, "R9 zeroing");
    // R4 bank bit drives the address MSB
    cycle(1, 4'd6, rule(1, 0, 0, 0, 5'd21, 5'd2), 0, 0, 0, 0, "R1 wr");
    cycle(0, 0, 0, 1, 0, 5'd21, '1, "R4 bank");
    // R6 duplicate keys: highest index wins
    cycle(1, 4'd2,  rule(0, 0, 0, 0, 5'd12, 5'd13), 0, 0, 0, 0, "R1 wr");
    cycle(1, 4'd10, rule(0, 1, 1, 0, 5'd12, 5'd14), 0, 0, 0, 0, "R1 wr");
    cycle(1, 4'd8,  rule(0, 0, 0, 0, 5'd12, 5'd15), 0, 0, 0, 0, "R1 wr");
    cycle(0, 0, 0, 1, 0, 5'd12, '1, "R6 dup");
    // R1 write and lookup of the same key in one cycle: old mapping
    cycle(1, 4'd3, rule(0, 0, 0, 0, 5'd7, 5'd30), 1, 0, 5'd7, '1, "R1 same cycle");
    cycle(0, 0, 0, 1, 0, 5'd7, '1, "R1 next cycle");
    cycle(0, 0, 0, 0, 0, 0, 0, "R7 idle");

    // random traffic
    for (int n = 0; n < 600; n++) begin
      bit we = ($urandom % 3) == 0;
      bit rq = ($urandom % 4) != 0;
      logic [13:0] wd = 14'($urandom);
      if (($urandom % 4) != 0) wd[13] = 1'b0;
      if (($urandom % 8) == 0) rf_m[$urandom % 64] = {$urandom, $urandom};
      el = {$urandom, $urandom};
      cycle(we, 4'($urandom), wd, rq, 1'($urandom), 5'($urandom % 8), el, "rand");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule